// File: doc/BRIEF.md
# PWM Phase-Alignment Sync Controller

This block decides when a group of PWM channels begins a new, phase-aligned run. It watches one trigger source at a time: either the falling edge of an internal load strobe, or the falling edge of an external sync pin that may be asynchronous to the core clock. When a trigger is accepted, a shared offset counter starts from zero. Each channel gets a one-cycle start pulse on the cycle its programmed offset is reached. Channels with equal offsets therefore start together, and the others follow in offset order.

For the external pin there are two modes. In the first, every falling edge aligns the channels. In the second, an alignment must first be armed by a load strobe while the pin is high, and the next falling edge then fires it once. A trigger can either cut running periods short (force mode) or wait until no channel reports a period still in progress. After a system reset, a software bring-up hold can keep the whole controller quiet until software releases it.

Top module: `pwm_align_ctrl`

## Requirements
- R1: With SW_BRINGUP=1 the controller comes out of system reset held: core_en_o is 0, triggers are ignored and start_o stays 0. A cycle with sw_wr_i=1 loads sw_rst_i into the hold (0 releases it, 1 holds it again), and core_en_o follows one clock later.
- R2: With src_ext_i=0 the trigger is the falling edge of load_i. For a one-cycle load_i pulse sampled at clock edge k, channel start pulses are computed from a counter restart at edge k+1, so an offset-0 channel pulses after edge k+2.
- R3: With src_ext_i=1, ext_sync_i passes a two-flop synchronizer and a registered falling-edge detector. A falling level first sampled at edge k restarts the counter at edge k+2, so an offset-0 channel pulses after edge k+3. Each fall gives exactly one trigger cycle.
- R4: With ext_align_i=1 and src_ext_i=1, every falling edge of the synchronized pin triggers an alignment.
- R5: With ext_align_i=0 and src_ext_i=1, a falling edge is ignored unless the controller is armed. A load_i cycle while the synchronized pin is high arms it, and the next falling edge triggers once and disarms it.
- R6: The offset of channel i is offsets_i[i*OFS_W +: OFS_W]. Its start_o[i] is a single-cycle pulse, issued exactly offset clocks after the offset-0 slot of the same run.
- R7: Channels with equal offsets pulse in the same cycle.
- R8: With force_align_i=0, an accepted trigger is held pending while any chan_busy_i bit is 1. The counter restarts at the first edge where all bits are 0, and the offset-0 pulse follows one edge later.
- R9: With force_align_i=1, a trigger restarts the counter regardless of chan_busy_i.
- R10: The counter idles after it reaches the largest programmed offset and produces no further pulses. A trigger during a run restarts it from 0, and pulses of the interrupted run that were not yet issued are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_sync_i | input | 1 | External sync pin, may be asynchronous |
| load_i | input | 1 | Load-configuration strobe |
| src_ext_i | input | 1 | Trigger source select: 1 external pin, 0 load strobe |
| ext_align_i | input | 1 | 1: every external fall aligns; 0: arm-once mode |
| force_align_i | input | 1 | 1: align immediately; 0: wait for idle channels |
| chan_busy_i | input | N_CH | Per-channel flag, 1 while a period is still running |
| offsets_i | input | N_CH*OFS_W | Packed per-channel start offsets |
| sw_wr_i | input | 1 | Software write strobe for the bring-up hold |
| sw_rst_i | input | 1 | Value written to the hold (1 hold, 0 run) |
| start_o | output | N_CH | Per-channel single-cycle start pulses |
| core_en_o | output | 1 | 1 when the controller is out of software hold |

## Verification
The bench aims at the exact trigger latency through the synchronizer and through the load-edge path. A design with one flop too many or too few in either path would move every start pulse by a cycle. It drives falling edges in arm-once mode before any arming, and a second edge after the armed one; a design that fails to disarm would emit extra pulse trains. It raises a channel-busy flag without force mode and checks that nothing starts until the flag drops. It also re-triggers in the middle of a run: a design that let the old run finish would produce the dropped late-offset pulses, and a counter that never idles would keep pulsing after the largest offset.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;
  typedef enum logic {
    SRC_LOAD = 1'b0,
    SRC_EXT  = 1'b1
  } sync_src_e;
endpackage

// File: rtl/pwm_sync_fall.sv
module pwm_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end else begin : g_single
      always_comb chain_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pwm_trig_ctrl.sv
module pwm_trig_ctrl
  import pwm_align_pkg::*;
#(
  parameter int N_CH       = 16,
  parameter bit SW_BRINGUP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_fall_i,
  input  logic            ext_lvl_i,
  input  logic            load_i,
  input  logic            src_ext_i,
  input  logic            ext_align_i,
  input  logic            force_align_i,
  input  logic [N_CH-1:0] chan_busy_i,
  input  logic            sw_wr_i,
  input  logic            sw_rst_i,
  output logic            go_o,
  output logic            hold_o
);
  logic load_q, armed_q, pend_q, hold_q;
  logic armed_d, pend_d, hold_d;
  logic load_fall, ext_trig, trig, clear_ok, arm_set, arm_use;
  sync_src_e src;

  always_comb begin
    src       = sync_src_e'(src_ext_i);
    load_fall = load_q & ~load_i;
    ext_trig  = ext_align_i ? ext_fall_i : (armed_q & ext_fall_i);
    trig      = (src == SRC_EXT) ? ext_trig : load_fall;
    clear_ok  = force_align_i | ~(|chan_busy_i);
    go_o      = ~hold_q & (trig | pend_q) & clear_ok;

    arm_set   = load_i & ext_lvl_i & (src == SRC_EXT) & ~ext_align_i;
    arm_use   = armed_q & ext_fall_i;
    hold_d    = sw_wr_i ? sw_rst_i : hold_q;

    if (hold_q) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end else begin
      armed_d = arm_set | (armed_q & ~arm_use);
      pend_d  = (pend_q | trig) & ~go_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= SW_BRINGUP;
    end else begin
      load_q  <= load_i;
      armed_q <= armed_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/pwm_ofs_sched.sv
module pwm_ofs_sched #(
  parameter int N_CH  = 16,
  parameter int OFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic                  hold_i,
  input  logic [N_CH*OFS_W-1:0] offsets_i,
  output logic [N_CH-1:0]       start_o,
  output logic [OFS_W-1:0]      cnt_o,
  output logic                  run_o,
  output logic [OFS_W-1:0]      max_o
);
  logic [OFS_W-1:0] ofs [N_CH];
  logic [OFS_W-1:0] cnt_q, cnt_d, max_d;
  logic             run_q, run_d;
  logic [N_CH-1:0]  start_q, start_d;

  genvar gi;
  generate
    for (gi = 0; gi < N_CH; gi++) begin : g_ch
      assign ofs[gi]     = offsets_i[gi*OFS_W +: OFS_W];
      assign start_d[gi] = run_q & ~hold_i & (cnt_q == ofs[gi]);
    end
  endgenerate

  always_comb begin
    max_d = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ofs[i] > max_d) max_d = ofs[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (hold_i) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (go_i) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q >= max_d) run_d = 1'b0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      start_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
  assign cnt_o   = cnt_q;
  assign run_o   = run_q;
  assign max_o   = max_d;
endmodule

// File: rtl/pwm_align_ctrl.sv
module pwm_align_ctrl #(
  parameter int N_CH        = 16,
  parameter int OFS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SW_BRINGUP  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_sync_i,
  input  logic                  load_i,
  input  logic                  src_ext_i,
  input  logic                  ext_align_i,
  input  logic                  force_align_i,
  input  logic [N_CH-1:0]       chan_busy_i,
  input  logic [N_CH*OFS_W-1:0] offsets_i,
  input  logic                  sw_wr_i,
  input  logic                  sw_rst_i,
  output logic [N_CH-1:0]       start_o,
  output logic                  core_en_o
);
  logic             ext_lvl_w, ext_fall_w, go_w, hold_w, run_w;
  logic [OFS_W-1:0] cnt_w, max_w;

  pwm_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (ext_sync_i),
    .lvl_o  (ext_lvl_w),
    .fall_o (ext_fall_w)
  );

  pwm_trig_ctrl #(.N_CH(N_CH), .SW_BRINGUP(SW_BRINGUP)) u_trig (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_fall_i    (ext_fall_w),
    .ext_lvl_i     (ext_lvl_w),
    .load_i        (load_i),
    .src_ext_i     (src_ext_i),
    .ext_align_i   (ext_align_i),
    .force_align_i (force_align_i),
    .chan_busy_i   (chan_busy_i),
    .sw_wr_i       (sw_wr_i),
    .sw_rst_i      (sw_rst_i),
    .go_o          (go_w),
    .hold_o        (hold_w)
  );

  pwm_ofs_sched #(.N_CH(N_CH), .OFS_W(OFS_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_w),
    .hold_i    (hold_w),
    .offsets_i (offsets_i),
    .start_o   (start_o),
    .cnt_o     (cnt_w),
    .run_o     (run_w),
    .max_o     (max_w)
  );

  assign core_en_o = ~hold_w;
endmodule

// File: rtl/pwm_align_chk.sv
module pwm_align_chk #(
  parameter int N_CH  = 16,
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_en,
  input logic [N_CH-1:0]  start,
  input logic             go,
  input logic             run,
  input logic             hold,
  input logic [OFS_W-1:0] cnt,
  input logic [OFS_W-1:0] max_ofs,
  input logic             force_align,
  input logic [N_CH-1:0]  busy,
  input logic             ext_fall
);
  // R1: two held cycles in a row mean no start pulse
  p_quiet_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && $past(!core_en)) |-> (start == '0));

  // R3: the edge detector yields one trigger cycle per fall
  p_single_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> !ext_fall);

  // R8: no restart while a channel is busy and force mode is off
  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_align && (|busy)) |-> !go);

  // R10: an accepted trigger restarts the counter at zero
  p_go_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (run && (cnt == '0)));

  // R10: the counter idles once the largest offset is reached
  p_run_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !go && !hold && (cnt >= max_ofs)) |=> !run);
endmodule

bind pwm_align_ctrl pwm_align_chk #(.N_CH(N_CH), .OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_en     (core_en_o),
  .start       (start_o),
  .go          (go_w),
  .run         (run_w),
  .hold        (hold_w),
  .cnt         (cnt_w),
  .max_ofs     (max_w),
  .force_align (force_align_i),
  .busy        (chan_busy_i),
  .ext_fall    (ext_fall_w)
);

// File: tb/tb_pwm_align_ctrl.sv
module tb_pwm_align_ctrl;
  localparam int N = 4;
  localparam int W = 8;

  logic clk, rst_n;
  logic ext_sync, load, src_ext, ext_align, force_al, sw_wr, sw_rst;
  logic [N-1:0]   busy;
  logic [N*W-1:0] offsets;
  logic [N-1:0]   start;
  logic           core_en;
  logic [W-1:0]   ofs [N];

  pwm_align_ctrl #(.N_CH(N), .OFS_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ext_sync_i(ext_sync), .load_i(load),
    .src_ext_i(src_ext), .ext_align_i(ext_align), .force_align_i(force_al),
    .chan_busy_i(busy), .offsets_i(offsets), .sw_wr_i(sw_wr), .sw_rst_i(sw_rst),
    .start_o(start), .core_en_o(core_en)
  );

  always_comb for (int i = 0; i < N; i++) offsets[i*W +: W] = ofs[i];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, pulses = 0;
  int seen [N];
  string cur_req = "R1";

  // behavioural reference state
  int m_s1, m_s2, m_prev, m_lq, m_arm, m_pend, m_run, m_cnt, m_hold;
  logic [N-1:0] m_start;

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int fall, lfall, trig, ok, go, mx, seti, use_a;
    logic [N-1:0] nstart;
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_lq = 0; m_arm = 0; m_pend = 0;
      m_run = 0; m_cnt = 0; m_hold = 1; m_start = '0;
    end else begin
      fall  = (m_prev == 1 && m_s2 == 0);
      lfall = (m_lq == 1 && load == 1'b0);
      if (src_ext) trig = ext_align ? fall : (fall && m_arm == 1);
      else         trig = lfall;
      ok = force_al || (busy == '0);
      go = (m_hold == 0) && (trig || m_pend == 1) && ok;
      mx = 0;
      foreach (ofs[i]) if (int'(ofs[i]) > mx) mx = int'(ofs[i]);
      foreach (ofs[i]) nstart[i] = (m_run == 1) && (m_hold == 0) && (m_cnt == int'(ofs[i]));
      if (m_hold == 1) begin
        m_arm = 0; m_pend = 0; m_run = 0; m_cnt = 0;
      end else begin
        seti  = load && (m_s2 == 1) && src_ext && !ext_align;
        use_a = (m_arm == 1) && fall;
        m_arm  = (seti || (m_arm == 1 && !use_a)) ? 1 : 0;
        m_pend = ((m_pend == 1 || trig) && !go) ? 1 : 0;
        if (go) begin m_run = 1; m_cnt = 0; end
        else if (m_run == 1) begin
          if (m_cnt >= mx) m_run = 0; else m_cnt++;
        end
      end
      if (sw_wr) m_hold = sw_rst ? 1 : 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_sync ? 1 : 0;
      m_lq = load ? 1 : 0;
      m_start = nstart;
    end
    #2;
    if (rst_n) begin
      check(cur_req, int'(start), int'(m_start), "start vector vs model");
      check("R1", int'(core_en), (m_hold == 0) ? 1 : 0, "core_en vs model");
      foreach (seen[i]) if (start[i] && seen[i] < 0) seen[i] = cyc;
      pulses += $countones(start);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seen();
    foreach (seen[i]) seen[i] = -1;
    pulses = 0;
  endtask

  task automatic pulse_load(output int mark);
    @(negedge clk); load = 1'b1; mark = cyc;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ext_drop(output int mark);
    @(negedge clk); ext_sync = 1'b0; mark = cyc;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; ext_sync = 1'b0; load = 1'b0; src_ext = 1'b1;
    ext_align = 1'b1; force_al = 1'b1; sw_wr = 1'b0; sw_rst = 1'b0; busy = '0;
    ofs[0] = 0; ofs[1] = 3; ofs[2] = 3; ofs[3] = 6;
    clear_seen();
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1", int'(core_en), 0, "core_en after reset");
    check("R1", int'(start), 0, "start after reset");

    // R1: edges while held are ignored
    cur_req = "R1";
    clear_seen();
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(12);
    check("R1", pulses, 0, "pulses while held");
    @(negedge clk); sw_wr = 1'b1; sw_rst = 1'b0;
    @(negedge clk); sw_wr = 1'b0;
    check("R1", int'(core_en), 1, "core_en after release");

    // R3/R6/R7: single aligned run via external pin
    cur_req = "R3";
    clear_seen();
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(14);
    check("R3", seen[0], c + 4, "offset-0 start cycle after ext fall");
    check("R6", seen[1] - seen[0], 3, "offset-3 spacing");
    check("R7", seen[2], seen[1], "equal offsets same cycle");
    check("R6", seen[3] - seen[0], 6, "offset-6 spacing");
    check("R6", pulses, 4, "one pulse per channel");

    // R4: every fall re-aligns
    cur_req = "R4";
    clear_seen();
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(14);
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(14);
    check("R4", pulses, 8, "two falls give two runs");

    // R5: arm-once mode
    cur_req = "R5";
    ext_align = 1'b0;
    clear_seen();
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(14);
    check("R5", pulses, 0, "unarmed fall ignored");
    ext_sync = 1'b1; tick(5); pulse_load(c); tick(2); ext_drop(c); tick(14);
    check("R5", pulses, 4, "armed fall fires once");
    check("R5", seen[0], c + 4, "armed fall latency");
    clear_seen();
    ext_sync = 1'b1; tick(5); ext_drop(c); tick(14);
    check("R5", pulses, 0, "second fall after use ignored");

    // R2: load strobe as source
    cur_req = "R2";
    src_ext = 1'b0;
    clear_seen();
    pulse_load(c); tick(14);
    check("R2", seen[0], c + 3, "load-edge latency");
    check("R2", pulses, 4, "load run pulses");

    // R8: wait for busy channels
    cur_req = "R8";
    force_al = 1'b0; busy = 4'b0010;
    clear_seen();
    pulse_load(c); tick(10);
    check("R8", pulses, 0, "held while busy");
    @(negedge clk); busy = '0; c = cyc; tick(14);
    check("R8", seen[0], c + 2, "start after busy drops");

    // R9: force mode ignores busy
    cur_req = "R9";
    force_al = 1'b1; busy = 4'b1111;
    clear_seen();
    pulse_load(c); tick(14);
    check("R9", seen[0], c + 3, "forced latency");
    check("R9", pulses, 4, "forced run pulses");
    busy = '0;

    // R10: retrigger mid-run, then idle
    cur_req = "R10";
    clear_seen();
    pulse_load(c); tick(1);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    tick(14);
    check("R10", seen[3], c + 12, "late channel after restart");
    check("R10", pulses, 5, "interrupted run dropped");
    tick(20);
    check("R10", pulses, 5, "idle after max offset");

    // R1: hold again
    cur_req = "R1";
    @(negedge clk); sw_wr = 1'b1; sw_rst = 1'b1;
    @(negedge clk); sw_wr = 1'b0;
    check("R1", int'(core_en), 0, "core_en after re-hold");
    clear_seen();
    pulse_load(c); tick(14);
    check("R1", pulses, 0, "load ignored in hold");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule